// File: doc/BRIEF.md
# Timer Prescaler Reset Synchronization Controller

This block holds an 8-bit control register that governs two timer prescalers. One prescaler runs on the system clock and is shared by every synchronous timer. The other runs on a separate timer clock, which may be unrelated to the system clock. Software can pulse a reset into either prescaler. It can also enter a synchronization mode in which the reset requests stay latched. This keeps every attached timer frozen while software configures them. Leaving that mode releases both prescalers in the same system cycle, so the timers start counting together.

Each prescaler is a free-running 10-bit counter. It emits one-cycle clock-enable pulses at divide-by-8, 64, 256 and 1024. A reset request for the second prescaler crosses into its clock domain through a two-flop synchronizer. An acknowledge returns to the system domain through a second two-flop synchronizer. While the second prescaler is in asynchronous mode, its request bit stays visible until that acknowledge arrives.

Top module: `tmr_psc_sync_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `sync_psc_rst` is low and no request is pending.
- R2: The register has three live bits: bit 7 is the synchronization-mode bit, bit 1 is the timer-clock prescaler reset and bit 0 is the shared prescaler reset. Bits 6..2 always read 0, and writing them has no effect.
- R3: With bit 7 written as 0, writing bit 0 as 1 drives `sync_psc_rst` high for exactly one cycle, starting in the cycle after the write. Bit 0 reads 0 from then on. Clearing takes priority over holding, but the reset pulse is still delivered.
- R4: With bit 7 written as 1, bits 1 and 0 keep the written values. While bit 0 is held, `sync_psc_rst` stays high and `sync_tick` stays 0. While bit 1 is held, `async_psc_rst` stays high.
- R5: A write with bit 7 as 0 clears both held bits in the same cycle. The shared prescaler restarts from zero, and its first divide-by-8 pulse comes 8 cycles after the last cycle in which `sync_psc_rst` was high.
- R6: With `async_mode` high, a write of bit 1 as 1 (bit 7 as 0) makes bit 1 read 1. It keeps reading 1 until `async_psc_rst` has been asserted in the timer-clock domain and acknowledged back, and it then clears on its own. A request written while the previous acknowledge is still draining reads 1 and gets its own reset.
- R7: A pending timer-clock request never clears while bit 7 is 1. It clears after bit 7 returns to 0 and the acknowledge is present.
- R8: Each prescaler tick output, index 0..3, is a one-cycle pulse of its own clock. Indices 0..3 have periods 8, 64, 256 and 1024. A pulse at index k implies a pulse at every lower index in the same cycle, and a prescaler reset returns the count to zero.
- R9: With `async_mode` low, bit 1 behaves like bit 0: it reads 0 after a write with bit 7 as 0, and a one-cycle request is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (system domain; synchronized into the timer-clock domain) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| aclk | input | 1 | Timer clock of the second prescaler |
| async_mode | input | 1 | High when the second prescaler runs asynchronously to `clk` |
| sync_psc_rst | output | 1 | Reset to the shared prescaler (system domain) |
| async_psc_rst | output | 1 | Reset to the second prescaler (`aclk` domain) |
| sync_tick | output | 4 | Shared prescaler enables: divide by 8, 64, 256, 1024 |
| async_tick | output | 4 | Second prescaler enables: divide by 8, 64, 256, 1024 (`aclk` domain) |

## Verification
The bench writes all 256 register values without asynchronous mode. After each write it checks the readback, the single reset pulse and the held value. A design that let the reserved bits or a cleared hold stick would show them in the readback. A design that stretched or dropped the pulse would break the tick phase.

Both tick outputs are modelled arithmetically from the reset outputs, so a wrong tap or a restart that is off by one is seen at once. The bench drives the handshake three ways: a single request, a request issued while the previous acknowledge is still draining, and a request pending across synchronization mode. A design that cleared the bit early, lost the second request or cleared the bit under synchronization mode would show a bit 1 value that disagrees with the `async_psc_rst` activity the bench records.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int CTRL_W   = 8;
    localparam int TSM_BIT  = 7;
    localparam int ARST_BIT = 1;
    localparam int SRST_BIT = 0;
    localparam int PSC_W    = 10;
    localparam int N_TAPS   = 4;
    localparam int SYNC_STG = 2;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_DROP = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic tsm;
        logic arst;
        logic srst;
    } ctrl_bits_t;

    // log2 of the division ratio for each tick index
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_bits_t b);
        logic [CTRL_W-1:0] r;
        r           = '0;
        r[TSM_BIT]  = b.tsm;
        r[ARST_BIT] = b.arst;
        r[SRST_BIT] = b.srst;
        return r;
    endfunction

endpackage

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
    parameter int STAGES = psc_pkg::SYNC_STG
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int W    = psc_pkg::PSC_W,
    parameter int NT   = psc_pkg::N_TAPS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [NT-1:0] tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < NT; g++) begin : g_tap
        localparam int L = psc_pkg::tap_log2(g);
        assign tick[g] = !clr && (cnt[L-1:0] == {L{1'b1}});
        if (g > 0) begin : g_nest
            assert_nested_tick_R8: assert property (@(posedge clk) disable iff (rst)
                tick[g] |-> tick[g-1]);
        end
    end
endmodule

// File: rtl/psc_ctrl_reg.sv
module psc_ctrl_reg
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              async_mode,
    input  logic              ack_in,
    output logic [CTRL_W-1:0] rd_data,
    output logic              srst_out,
    output logic              req_out
);
    ctrl_bits_t wbits;
    logic       tsm_q, s_hold, a_hold, s_pulse, a_pulse;
    logic       again_q, again_d, start;
    hs_state_e  hs_q, hs_d;

    assign wbits = '{tsm: wr_data[TSM_BIT], arst: wr_data[ARST_BIT], srst: wr_data[SRST_BIT]};

    // handshake only for a plain (non-hold) request in asynchronous mode
    assign start = wr_en && wbits.arst && !wbits.tsm && async_mode;

    always_comb begin
        hs_d    = hs_q;
        again_d = again_q;
        case (hs_q)
            HS_IDLE: if (start) hs_d = HS_REQ;
            HS_REQ:  if (ack_in && !tsm_q) hs_d = HS_DROP;
            HS_DROP: begin
                if (!ack_in) begin
                    hs_d    = (again_q || start) ? HS_REQ : HS_IDLE;
                    again_d = 1'b0;
                end else if (start) begin
                    again_d = 1'b1;
                end
            end
            default: hs_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tsm_q   <= 1'b0;
            s_hold  <= 1'b0;
            a_hold  <= 1'b0;
            s_pulse <= 1'b0;
            a_pulse <= 1'b0;
            again_q <= 1'b0;
            hs_q    <= HS_IDLE;
        end else begin
            s_pulse <= wr_en && wbits.srst;
            a_pulse <= wr_en && wbits.arst && !async_mode;
            if (wr_en) begin
                tsm_q  <= wbits.tsm;
                s_hold <= wbits.tsm && wbits.srst;
                a_hold <= wbits.tsm && wbits.arst;
            end
            again_q <= again_d;
            hs_q    <= hs_d;
        end
    end

    assign srst_out = s_hold || s_pulse;
    assign req_out  = a_hold || a_pulse || (hs_q == HS_REQ);
    assign rd_data  = ctrl_pack('{tsm: tsm_q,
                                  arst: a_hold || (hs_q == HS_REQ) || again_q,
                                  srst: s_hold});

    assert_self_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tsm_q) |=> !rd_data[SRST_BIT]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (tsm_q && s_hold && !wr_en) |=> srst_out);

    assert_joint_release_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(tsm_q) |-> (!s_hold && !a_hold));

    assert_wait_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (hs_q == HS_REQ && !ack_in) |=> rd_data[ARST_BIT]);

    assert_no_clear_in_tsm_R7: assert property (@(posedge clk) disable iff (rst)
        (tsm_q && !wr_en && rd_data[ARST_BIT]) |=> rd_data[ARST_BIT]);
endmodule

// File: rtl/tmr_psc_sync_ctrl.sv
module tmr_psc_sync_ctrl
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              aclk,
    input  logic              async_mode,
    output logic              sync_psc_rst,
    output logic              async_psc_rst,
    output logic [N_TAPS-1:0] sync_tick,
    output logic [N_TAPS-1:0] async_tick
);
    logic                req, ack;
    logic [SYNC_STG-1:0] a_rst_pipe;
    logic                a_rst;

    // system reset carried into the timer-clock domain
    always_ff @(posedge aclk) a_rst_pipe <= {a_rst_pipe[SYNC_STG-2:0], rst};
    assign a_rst = a_rst_pipe[SYNC_STG-1];

    psc_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .async_mode (async_mode),
        .ack_in     (ack),
        .rd_data    (rd_data),
        .srst_out   (sync_psc_rst),
        .req_out    (req)
    );

    cdc_bit_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk (aclk), .rst (a_rst), .d (req), .q (async_psc_rst)
    );

    cdc_bit_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk (clk), .rst (rst), .d (async_psc_rst), .q (ack)
    );

    psc_counter #(.W(PSC_W), .NT(N_TAPS)) u_sync_psc (
        .clk (clk), .rst (rst), .clr (sync_psc_rst), .tick (sync_tick)
    );

    psc_counter #(.W(PSC_W), .NT(N_TAPS)) u_async_psc (
        .clk (aclk), .rst (a_rst), .clr (async_psc_rst), .tick (async_tick)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0 && !sync_psc_rst));
endmodule

// File: tb/tmr_psc_sync_ctrl_tb.sv
module tmr_psc_sync_ctrl_tb;
    logic       clk = 1'b0, aclk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, async_mode = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sync_psc_rst, async_psc_rst;
    logic [3:0] sync_tick, async_tick;

    int checks = 0, errors = 0;
    int s_since = 0, a_since = 0;
    bit s_en = 0, a_en = 0, seen_arst = 0;

    always #2 clk = ~clk;
    always #5 aclk = ~aclk;

    tmr_psc_sync_ctrl u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_data), .aclk (aclk), .async_mode (async_mode),
        .sync_psc_rst (sync_psc_rst), .async_psc_rst (async_psc_rst),
        .sync_tick (sync_tick), .async_tick (async_tick)
    );

    function automatic int tap_p(input int i);
        case (i)
            0: return 8;
            1: return 64;
            2: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic logic [3:0] exp_ticks(input int since);
        logic [3:0] t;
        for (int i = 0; i < 4; i++) t[i] = (since > 0) && (since % tap_p(i) == 0);
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // shared prescaler model (R8, R5)
    always @(negedge clk) begin
        if (!rst && sync_psc_rst) s_en = 1;
        if (s_en) begin
            if (sync_psc_rst) s_since = 0; else s_since++;
            chk(sync_tick == exp_ticks(s_since), "R8 sync_tick", sync_tick, exp_ticks(s_since));
        end
    end

    // timer-clock prescaler model (R8, R4)
    always @(negedge aclk) begin
        if (async_psc_rst) begin seen_arst = 1; a_en = 1; end
        if (a_en) begin
            if (async_psc_rst) a_since = 0; else a_since++;
            chk(async_tick == exp_ticks(a_since), "R8 async_tick", async_tick, exp_ticks(a_since));
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // n0 is the model count at the current negedge; first pulse index k at 2^tap
    task automatic first_ticks(input int n0, input string req);
        int first [4];
        int n = n0;
        for (int i = 0; i < 4; i++) first[i] = 0;
        while (n < 1100) begin
            @(negedge clk); n++;
            for (int i = 0; i < 4; i++) if (sync_tick[i] && first[i] == 0) first[i] = n;
        end
        for (int i = 0; i < 4; i++) chk(first[i] == tap_p(i), req, first[i], tap_p(i));
    endtask

    task automatic wait_abit_clear(input string req, output int waited);
        waited = 0;
        while (rd_data[1] && waited < 200) begin @(negedge clk); waited++; end
        chk(!rd_data[1], req, rd_data[1], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        repeat (20) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 8'h00, "R1 reset readback", rd_data, 0);
        chk(!sync_psc_rst, "R1 sync reset low", sync_psc_rst, 0);

        // R2 R3 R4 R9: every register value, non-asynchronous mode
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b = v[7:0];
            logic [7:0] e = {b[7], 5'b0, b[7] & b[1], b[7] & b[0]};
            wr(b);
            chk(rd_data == e, "R2 R9 readback", rd_data, e);
            chk(sync_psc_rst == b[0], "R3 pulse start", sync_psc_rst, b[0]);
            @(negedge clk);
            chk(sync_psc_rst == (b[7] & b[0]), "R3 R4 pulse end or hold", sync_psc_rst, b[7] & b[0]);
            chk(rd_data == e, "R4 value kept", rd_data, e);
        end

        // R8: divide ratios after a plain reset pulse
        wr(8'h00);
        repeat (3) @(negedge clk);
        wr(8'h01);
        first_ticks(0, "R8 first tick");

        // R4 R5: hold both prescalers, then release together
        async_mode = 1'b1;
        wr(8'h83);
        seen_arst = 0;
        repeat (60) begin
            @(negedge clk);
            chk(rd_data == 8'h83 && sync_psc_rst && sync_tick == 0, "R4 held", rd_data, 8'h83);
        end
        chk(seen_arst && async_psc_rst, "R4 async held", async_psc_rst, 1);
        wr(8'h80);
        chk(rd_data == 8'h80, "R4 written zero kept", rd_data, 8'h80);
        wr(8'h83);
        repeat (10) @(negedge clk);
        wr(8'h00);
        chk(rd_data == 8'h00 && !sync_psc_rst, "R5 joint clear", rd_data, 0);
        first_ticks(1, "R5 restart phase");

        // R6: single request waits for the acknowledge
        repeat (40) @(negedge clk);
        seen_arst = 0;
        wr(8'h02);
        chk(rd_data[1] == 1'b1, "R6 bit set", rd_data[1], 1);
        wait_abit_clear("R6 bit clears", w);
        chk(seen_arst, "R6 reset reached timer domain", seen_arst, 1);
        chk(w >= 2, "R6 not cleared early", w, 2);

        // R6: request issued while the acknowledge drains
        wr(8'h02);
        chk(rd_data[1] == 1'b1, "R6 second request visible", rd_data[1], 1);
        wait_abit_clear("R6 second request clears", w);
        repeat (40) @(negedge clk);

        // R7: pending request under synchronization mode
        wr(8'h02);
        wr(8'h80);
        repeat (40) begin
            @(negedge clk);
            chk(rd_data == 8'h82, "R7 no clear in sync mode", rd_data, 8'h82);
        end
        wr(8'h00);
        chk(rd_data[7] == 1'b0, "R7 mode off", rd_data[7], 0);
        repeat (3) @(negedge clk);
        chk(rd_data == 8'h00, "R7 clears after mode off", rd_data, 0);

        // R9: non-asynchronous bit 1 clears at once
        repeat (40) @(negedge clk);
        async_mode = 1'b0;
        wr(8'h02);
        chk(rd_data == 8'h00, "R9 immediate clear", rd_data, 0);

        repeat (20) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule